// File: doc/BRIEF.md
# Memory Bitfield Operation Unit

This unit carries out one bitfield operation at a time on a field that lives in byte-addressed memory. A request names a base byte address, a signed bit offset counted from the most significant bit of that byte, a width code, an operation and, for insertion, a source value. The unit works out which bytes the field covers. It fetches them one at a time over a byte-wide valid/ready memory port. It then computes the result and, for the modifying operations, writes the changed bytes back.

Seven operations are supported: unsigned extract, signed extract, insert, invert, clear, set and find-first-one. Every operation returns a 32-bit result together with a left-aligned field word. The negative and zero flags are taken from that word, so the surrounding core can update its condition codes without decoding the field again. Memory faults are handled outside this unit.

Top module: `bitfield_mem_unit`

## Requirements
- R1: The 5-bit width code gives the field width directly for codes 1 to 31; code 0 selects a 32-bit field.
- R2: The offset is a signed 32-bit two's complement value. The first byte touched is the base address plus floor(offset/8), and the field starts at bit position offset mod 8 (0 to 7) of that byte, where position 0 is the byte's most significant bit.
- R3: For every operation the unit issues exactly ((offset mod 8 + width − 1) div 8) + 1 reads (1 to 5), one byte per request, at ascending addresses from the first byte. It waits for each read response (mem_rvalid) before it issues the next request.
- R4: Field bit 0 is the most significant bit of the first byte, with later bits following in big-endian order. Op code 0 (and the spare code 7) returns the field zero-extended, with the field's last bit at result bit 0.
- R5: Op code 1 returns the field sign-extended from its first (most significant) bit.
- R6: Op code 2 writes the low `width` bits of req_value into the field. Both result and field_top equal req_value shifted left by 32 − width.
- R7: Op codes 3, 4 and 5 invert, clear or set every field bit in memory. Both result and field_top equal the original field shifted so that its first bit sits at bit 31, with zeros below it.
- R8: Op code 6 returns req_offset plus the number of leading zero bits in the field, or req_offset plus the width when the field is all zeros, as a 32-bit sum that wraps.
- R9: Op codes 2 to 5 write back the same bytes in ascending address order, and only after all reads have completed. Codes 0, 1, 6 and 7 issue no writes. Memory bits outside the field are never changed.
- R10: While mem_valid is high and mem_ready is low, mem_valid, mem_addr, mem_we and mem_wdata hold their values into the next cycle.
- R11: done is a one-cycle pulse after the last memory transfer, and result, field_top, flag_n and flag_z are valid in that cycle. For op codes other than 2, 3, 4 and 5, field_top is the original field left-aligned at bit 31 with zeros below it. flag_n is field_top bit 31 and flag_z is high when field_top is zero. req_ready is high only while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request present |
| req_ready | output | 1 | Unit idle, request is taken this cycle |
| req_op | input | 3 | Operation code (0 extu, 1 exts, 2 insert, 3 invert, 4 clear, 5 set, 6 find-first-one, 7 as 0) |
| req_addr | input | ADDR_W | Base byte address |
| req_offset | input | 32 | Signed bit offset from the base byte's most significant bit |
| req_width | input | 5 | Width code, 0 means 32 |
| req_value | input | 32 | Source value for insert |
| mem_valid | output | 1 | Memory byte request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 8 | Read byte |
| done | output | 1 | Operation complete, outputs valid |
| result | output | 32 | Operation result |
| field_top | output | 32 | Flag source word, field left-aligned at bit 31 |
| flag_n | output | 1 | Negative flag source |
| flag_z | output | 1 | Zero flag source |

## Verification
If the byte index or the span count is wrong, the very next memory handshake shows it as an address outside the expected ascending run, or as an extra or a missing request, so the reference model compares every handshake as it happens. If the captured window is corrupt, the result and the flags are wrong in the done cycle. For modifying operations the written bytes are wrong within a few cycles of that. To catch a byte or bit outside the field that was changed by mistake, the whole memory image is compared against the reference after every operation. Stall patterns on mem_ready test that a request holds steady until it is accepted.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
    localparam int FIELD_W   = 32;
    localparam int CODE_W    = $clog2(FIELD_W);
    localparam int LEN_W     = CODE_W + 1;
    localparam int BYTE_W    = 8;
    localparam int BOFS_W    = $clog2(BYTE_W);
    localparam int WIN_BYTES = FIELD_W / BYTE_W + 1;
    localparam int WIN_W     = WIN_BYTES * BYTE_W;
    localparam int IDX_W     = $clog2(WIN_BYTES + 1);

    typedef enum logic [2:0] {
        OP_EXTU = 3'd0, OP_EXTS = 3'd1, OP_INS = 3'd2, OP_CHG = 3'd3,
        OP_CLR  = 3'd4, OP_SET  = 3'd5, OP_FFO = 3'd6, OP_SPARE = 3'd7
    } bf_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR, ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic [LEN_W-1:0]  width;
        logic [BOFS_W-1:0] bofs;
        logic [IDX_W-1:0]  nbytes;
    } span_t;

    function automatic logic op_writes(bf_op_e op);
        return (op == OP_INS) || (op == OP_CHG) || (op == OP_CLR) || (op == OP_SET);
    endfunction

    // leading zero count; returns FIELD_W for an all-zero word
    function automatic logic [LEN_W-1:0] lead_zeros(logic [FIELD_W-1:0] v);
        logic [LEN_W-1:0] cnt;
        cnt = LEN_W'(FIELD_W);
        for (int i = 0; i < FIELD_W; i++) begin
            if (v[i]) cnt = LEN_W'(FIELD_W - 1 - i);
        end
        return cnt;
    endfunction
endpackage

// File: rtl/bfu_span.sv
module bfu_span
    import bfu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]  base_in,
    input  logic [FIELD_W-1:0] offset,
    input  logic [CODE_W-1:0]  width_code,
    output logic [ADDR_W-1:0]  first_addr,
    output span_t              span
);
    logic [FIELD_W-1:0] byte_step;
    logic [LEN_W-1:0]   reach;

    always_comb begin
        span.width  = (width_code == '0) ? LEN_W'(FIELD_W) : LEN_W'(width_code);
        span.bofs   = offset[BOFS_W-1:0];
        // arithmetic shift gives floor division for negative offsets
        byte_step   = FIELD_W'($signed(offset) >>> BOFS_W);
        first_addr  = base_in + ADDR_W'($signed(byte_step));
        reach       = LEN_W'(span.bofs) + span.width - LEN_W'(1);
        span.nbytes = IDX_W'(reach >> BOFS_W) + IDX_W'(1);
    end
endmodule

// File: rtl/bfu_field.sv
module bfu_field
    import bfu_pkg::*;
(
    input  bf_op_e             op,
    input  span_t              span,
    input  logic [WIN_W-1:0]   window,
    input  logic [FIELD_W-1:0] value,
    input  logic [FIELD_W-1:0] offset,
    output logic [WIN_W-1:0]   new_window,
    output logic [WIN_W-1:0]   field_mask,
    output logic [FIELD_W-1:0] result,
    output logic [FIELD_W-1:0] field_top
);
    localparam int PAD_BITS = WIN_W - FIELD_W;

    logic [LEN_W-1:0]   pad;
    logic [LEN_W-1:0]   ffo_cnt;
    logic [3:0]         down;
    logic [FIELD_W-1:0] raw_top, mask_top, fld_left, fld_u, fld_s, ins_left;
    logic [WIN_W-1:0]   ins_win;

    always_comb begin
        pad      = LEN_W'(FIELD_W) - span.width;
        down     = 4'(BYTE_W) - 4'(span.bofs);
        raw_top  = FIELD_W'(window >> down);
        mask_top = ~({FIELD_W{1'b1}} >> span.width);
        fld_left = raw_top & mask_top;
        fld_u    = fld_left >> pad;
        fld_s    = FIELD_W'($signed(fld_left) >>> pad);
        field_mask = {mask_top, {PAD_BITS{1'b0}}} >> span.bofs;
        ins_left = value << pad;
        ins_win  = {ins_left, {PAD_BITS{1'b0}}} >> span.bofs;
        ffo_cnt  = (fld_left == '0) ? span.width : lead_zeros(fld_left);

        new_window = window;
        field_top  = fld_left;
        result     = fld_u;
        case (op)
            OP_EXTS: result = fld_s;
            OP_INS: begin
                new_window = (window & ~field_mask) | ins_win;
                field_top  = ins_left;
                result     = ins_left;
            end
            OP_CHG: begin
                new_window = window ^ field_mask;
                result     = fld_left;
            end
            OP_CLR: begin
                new_window = window & ~field_mask;
                result     = fld_left;
            end
            OP_SET: begin
                new_window = window | field_mask;
                result     = fld_left;
            end
            OP_FFO:  result = offset + FIELD_W'(ffo_cnt);
            default: result = fld_u;
        endcase
    end
endmodule

// File: rtl/bfu_seq.sv
module bfu_seq
    import bfu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [ADDR_W-1:0]  first_addr,
    input  logic [IDX_W-1:0]   nbytes,
    input  logic               writes,
    input  logic [WIN_W-1:0]   new_window,
    output logic [WIN_W-1:0]   window,
    output logic               req_ready,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0]  mem_wdata,
    input  logic               mem_rvalid,
    input  logic [BYTE_W-1:0]  mem_rdata,
    output logic               done
);
    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             last;

    assign last = (idx == nbytes - IDX_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            window <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    idx    <= '0;
                    window <= '0;
                    state  <= ST_RD_REQ;
                end
                ST_RD_REQ: if (mem_ready) state <= ST_RD_WAIT;
                ST_RD_WAIT: if (mem_rvalid) begin
                    window[WIN_W-1-BYTE_W*int'(idx) -: BYTE_W] <= mem_rdata;
                    if (last) begin
                        idx   <= '0;
                        state <= writes ? ST_WR : ST_FIN;
                    end else begin
                        idx   <= idx + IDX_W'(1);
                        state <= ST_RD_REQ;
                    end
                end
                ST_WR: if (mem_ready) begin
                    if (last) state <= ST_FIN;
                    else      idx   <= idx + IDX_W'(1);
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        done      = (state == ST_FIN);
        mem_valid = (state == ST_RD_REQ) || (state == ST_WR);
        mem_we    = (state == ST_WR);
        mem_addr  = first_addr + ADDR_W'(idx);
        mem_wdata = new_window[WIN_W-1-BYTE_W*int'(idx) -: BYTE_W];
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))
        else $error("request changed while stalled");

    assert_idx_bound_R3: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> idx < nbytes)
        else $error("byte index beyond span");

    assert_store_gate_R9: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_we |-> writes)
        else $error("store issued for a read-only operation");

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && req_ready)
        else $error("done longer than one cycle");

    assert_accept_R11: assert property (@(posedge clk) disable iff (rst)
        start |=> !req_ready && mem_valid && !mem_we)
        else $error("accepted request did not start a read");
endmodule

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit
    import bfu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [2:0]         req_op,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [FIELD_W-1:0] req_offset,
    input  logic [CODE_W-1:0]  req_width,
    input  logic [FIELD_W-1:0] req_value,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0]  mem_wdata,
    input  logic               mem_rvalid,
    input  logic [BYTE_W-1:0]  mem_rdata,
    output logic               done,
    output logic [FIELD_W-1:0] result,
    output logic [FIELD_W-1:0] field_top,
    output logic               flag_n,
    output logic               flag_z
);
    bf_op_e             q_op;
    logic [ADDR_W-1:0]  q_addr;
    logic [FIELD_W-1:0] q_offset;
    logic [CODE_W-1:0]  q_code;
    logic [FIELD_W-1:0] q_value;
    logic               start;
    logic [ADDR_W-1:0]  first_addr;
    span_t              span;
    logic [WIN_W-1:0]   window, new_window, field_mask;

    assign start = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_op     <= OP_EXTU;
            q_addr   <= '0;
            q_offset <= '0;
            q_code   <= '0;
            q_value  <= '0;
        end else if (start) begin
            q_op     <= bf_op_e'(req_op);
            q_addr   <= req_addr;
            q_offset <= req_offset;
            q_code   <= req_width;
            q_value  <= req_value;
        end
    end

    bfu_span #(.ADDR_W(ADDR_W)) u_span (
        .base_in(q_addr), .offset(q_offset), .width_code(q_code),
        .first_addr(first_addr), .span(span)
    );

    bfu_field u_field (
        .op(q_op), .span(span), .window(window), .value(q_value), .offset(q_offset),
        .new_window(new_window), .field_mask(field_mask),
        .result(result), .field_top(field_top)
    );

    bfu_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .first_addr(first_addr),
        .nbytes(span.nbytes), .writes(op_writes(q_op)), .new_window(new_window),
        .window(window), .req_ready(req_ready), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done)
    );

    assign flag_n = field_top[FIELD_W-1];
    assign flag_z = (field_top == '0);

    assert_mask_width_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> $countones(field_mask) == int'(span.width))
        else $error("field mask does not match width");

    assert_ffo_range_R8: assert property (@(posedge clk) disable iff (rst)
        done && q_op == OP_FFO |-> (result - q_offset) <= FIELD_W'(span.width))
        else $error("find-first-one beyond field");
endmodule

// File: tb/bitfield_mem_unit_test.sv
module bitfield_mem_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_offset = '0;
    logic [4:0]  req_width = '0;
    logic [31:0] req_value = '0;
    logic        mem_valid, mem_we;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        done, flag_n, flag_z;
    logic [31:0] result, field_top;

    always #5 clk = ~clk;

    bitfield_mem_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_offset(req_offset),
        .req_width(req_width), .req_value(req_value), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .result(result), .field_top(field_top),
        .flag_n(flag_n), .flag_z(flag_z)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0]  dut_mem [256];
    logic [7:0]  ref_mem [256];
    logic [31:0] q_addr [$];
    logic        q_we [$];
    logic [7:0]  q_wd [$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_test();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // memory model and per-handshake comparison against the expected access list
    bit          pend = 0;
    logic [7:0]  pend_data = '0;
    int          cyc = 0;
    bit          prev_stall = 0;
    logic [31:0] prev_addr = '0;

    always @(negedge clk) begin
        logic [31:0] ea;
        logic        ew;
        logic [7:0]  ed;
        if (rst) begin
            mem_ready = 1'b0; mem_rvalid = 1'b0; pend = 0; prev_stall = 0;
        end else begin
            mem_rvalid = pend;
            mem_rdata  = pend_data;
            pend       = 0;
            if (prev_stall)
                check(mem_valid === 1'b1 && mem_addr == prev_addr, "R10",
                      "stalled request address", mem_addr, prev_addr);
            cyc++;
            mem_ready  = (cyc % 3) != 1;
            prev_stall = mem_valid && !mem_ready;
            prev_addr  = mem_addr;
            if (mem_valid && mem_ready) begin
                if (q_addr.size() == 0) begin
                    check(0, "R3 R9", "unexpected memory access", mem_addr, 0);
                end else begin
                    ea = q_addr.pop_front();
                    ew = q_we.pop_front();
                    ed = q_wd.pop_front();
                    check(mem_addr == ea, "R3", "access address", mem_addr, ea);
                    check(mem_we == ew, "R9", "access direction", mem_we, ew);
                    if (ew) check(mem_wdata == ed, "R9", "stored byte", mem_wdata, ed);
                end
                if (mem_we) dut_mem[mem_addr[7:0]] = mem_wdata;
                else begin
                    pend = 1;
                    pend_data = dut_mem[mem_addr[7:0]];
                end
            end
        end
    end

    task automatic run_op(input int op, input int addr, input int off, input int wc,
                          input logic [31:0] val, input string tag);
        int w, start, base, bofs, n, ab, first, waited, bad;
        logic [31:0] fu, left, exp_res, exp_top;
        logic b, nb;
        w = (wc == 0) ? 32 : wc;
        start = addr * 8 + off;
        base  = start >>> 3;
        bofs  = start & 7;
        n     = (bofs + w - 1) / 8 + 1;
        fu = '0;
        first = w;
        for (int i = 0; i < w; i++) begin
            ab = start + i;
            b  = ref_mem[ab >> 3][7 - (ab & 7)];
            fu = {fu[30:0], b};
            if (b && first == w) first = i;
        end
        left = fu << (32 - w);
        for (int k = 0; k < n; k++) begin
            q_addr.push_back(32'(base + k)); q_we.push_back(1'b0); q_wd.push_back(8'h00);
        end
        exp_top = left;
        exp_res = left;
        case (op)
            1: begin
                exp_res = fu;
                if (fu[w-1]) exp_res = fu | (32'hFFFF_FFFF << w);
            end
            2: begin
                exp_top = val << (32 - w);
                exp_res = exp_top;
            end
            3, 4, 5: ;
            6: exp_res = 32'(off + first);
            default: exp_res = fu;
        endcase
        if (op >= 2 && op <= 5) begin
            for (int i = 0; i < w; i++) begin
                ab = start + i;
                b  = ref_mem[ab >> 3][7 - (ab & 7)];
                case (op)
                    2: nb = val[w - 1 - i];
                    3: nb = ~b;
                    4: nb = 1'b0;
                    default: nb = 1'b1;
                endcase
                ref_mem[ab >> 3][7 - (ab & 7)] = nb;
            end
            for (int k = 0; k < n; k++) begin
                q_addr.push_back(32'(base + k)); q_we.push_back(1'b1);
                q_wd.push_back(ref_mem[base + k]);
            end
        end

        @(negedge clk);
        req_op = 3'(op); req_addr = 32'(addr); req_offset = 32'(off);
        req_width = 5'(wc); req_value = val; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (done !== 1'b1 && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        check(done === 1'b1, tag, "done pulse", done, 1);
        check(result == exp_res, tag, "result", result, exp_res);
        check(field_top == exp_top, "R11", "field_top", field_top, exp_top);
        check(flag_n == exp_top[31], "R11", "flag_n", flag_n, exp_top[31]);
        check(flag_z == (exp_top == 0), "R11", "flag_z", flag_z, exp_top == 0);
        check(q_addr.size() == 0, "R3", "accesses still expected", q_addr.size(), 0);
        bad = 0;
        for (int j = 0; j < 256; j++) if (dut_mem[j] !== ref_mem[j]) bad++;
        check(bad == 0, "R9", "memory bytes differing", bad, 0);
        q_addr.delete(); q_we.delete(); q_wd.delete();
        @(negedge clk);
        check(done === 1'b0 && req_ready === 1'b1, "R11", "done single cycle / idle",
              {done, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", "run did not complete", 0, 1);
        finish_test();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            dut_mem[i] = 8'((i * 37 + 11) & 255);
            ref_mem[i] = dut_mem[i];
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready === 1'b1 && done === 1'b0 && mem_valid === 1'b0, "R11",
              "reset state", {req_ready, done, mem_valid}, 3'b100);

        run_op(0, 64, 0, 8, 32'h0, "R4");                 // whole single byte
        run_op(0, 64, 3, 0, 32'h0, "R1 R3 R4");           // 32-bit field over 5 bytes
        run_op(1, 80, -5, 7, 32'h0, "R2 R5");             // negative offset, floor addressing
        run_op(1, 81, 9, 12, 32'h0, "R5");
        run_op(1, 90, -1, 1, 32'h0, "R2 R5");             // single bit in previous byte
        run_op(7, 70, 17, 11, 32'h0, "R4");               // spare code acts as unsigned extract
        run_op(2, 100, 13, 19, 32'hDEAD_BEEF, "R6");
        run_op(0, 100, 13, 19, 32'h0, "R6");              // read back inserted field
        run_op(2, 120, -20, 0, 32'h8000_0001, "R1 R6");
        run_op(3, 140, 5, 10, 32'h0, "R7");
        run_op(4, 150, 2, 20, 32'h0, "R7");
        run_op(5, 160, 7, 2, 32'h0, "R7");
        run_op(6, 150, 2, 20, 32'h0, "R8");               // cleared field: offset + width
        run_op(6, 40, -30, 16, 32'h0, "R8");
        run_op(6, 160, 7, 2, 32'h0, "R8");                // all-ones field: count 0
        run_op(0, 30, 6, 3, 32'h0, "R3 R4");              // field straddles two bytes
        finish_test();
    end
endmodule